// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block is the digital control side of a 32-tap potentiometer. A host drives three lines: an active-low select, a direction level and an active-low step strobe. While the block is selected, each falling edge of the step strobe moves a 5-bit wiper position one place. The direction level picks the way. The position stops at both ends and never wraps. It is decoded into a one-hot tap-select vector that would drive the switch network of a resistor ladder.

The block holds a persistent copy of the position. Only a cold reset clears this copy, to mid-scale. A warm reset, or the power-up sequence, loads the position from it. When select is released, the level of the step line at that moment decides the outcome. If the step line is high, the position is written to the persistent copy and a busy period of `STORE_CYCLES` clocks follows. If it is low, the block returns to standby without writing.

The control is a four-state machine:
- `ST_RECALL` loads the position from the persistent copy for one cycle after any reset, then goes to `ST_STANDBY`.
- `ST_STANDBY` moves to `ST_ACTIVE` when select is low.
- `ST_ACTIVE` moves to `ST_STORE` when select rises while the step line is high, and to `ST_STANDBY` when select rises while the step line is low.
- `ST_STORE` returns to `ST_STANDBY` when its cycle count ends.

All three inputs pass through two-flop synchronizers before any logic uses them.

Top module: `wiper_ctrl`

## Requirements
- R1: When either reset is released, the position is loaded from the persistent copy. A cold reset sets that copy to 15. After a reset, busy is low and standby is high.
- R2: While selected, each falling edge of `step_n` moves the position by exactly one. The move is upward when `dir_up` is 1 and downward when `dir_up` is 0.
- R3: `tap_sel` always has exactly one bit set, and the set bit index equals `position`.
- R4: The position saturates at 31 when counting up and at 0 when counting down. It does not wrap.
- R5: While `sel_n` is high, edges on `step_n` leave the position unchanged.
- R6: If `sel_n` rises while `step_n` is high, the position is copied to the persistent register. `busy` is then high for exactly `STORE_CYCLES` clock cycles.
- R7: If `sel_n` rises while `step_n` is low, the persistent copy is unchanged, `busy` stays low and the block enters standby.
- R8: Step edges that arrive while `busy` is high are ignored.
- R9: A warm reset keeps the persistent copy and reloads the position from it.
- R10: `dir_up` may change between steps while the block stays selected. Each step follows the direction in force at its own edge.
- R11: `standby` is high only when the block is deselected and idle. It is low while the block is selected and while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Active-low asynchronous cold reset; also sets the persistent copy to mid-scale |
| warm_rst_n | input | 1 | Active-low asynchronous warm reset; the persistent copy is kept |
| sel_n | input | 1 | Active-low select (asynchronous) |
| dir_up | input | 1 | Step direction: 1 counts up, 0 counts down (asynchronous) |
| step_n | input | 1 | Step strobe; acts on its falling edge (asynchronous) |
| tap_sel | output | 32 | One-hot tap enable |
| position | output | 5 | Current wiper position |
| busy | output | 1 | High while a store is in progress |
| standby | output | 1 | High when deselected and idle |

## Verification
The tests run runs of up-steps and down-steps, and runs that flip direction between steps. These tell an off-by-one or inverted direction apart from correct counting. Long runs past both ends show whether the counter saturates or wraps. Each kind of deselect is followed by a warm reset, so the recalled position shows whether a write happened. One test sends step pulses while the block is deselected, and another sends them during the busy window. These prove the counter is gated in both states.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
    typedef enum logic [1:0] {
        ST_RECALL  = 2'd0,
        ST_STANDBY = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_STORE   = 2'd3
    } wstate_e;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
    parameter int N = 3,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            logic meta_q;
            logic stab_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    meta_q <= RST_VAL[i];
                    stab_q <= RST_VAL[i];
                end else begin
                    meta_q <= din[i];
                    stab_q <= meta_q;
                end
            end
            assign dout[i] = stab_q;
        end
    endgenerate
endmodule

// File: rtl/pos_counter.sv
module pos_counter #(
    parameter int PW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] load_val,
    input  logic          en,
    input  logic          up,
    output logic [PW-1:0] pos
);
    localparam logic [PW-1:0] MAX = {PW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (load) begin
            pos <= load_val;
        end else if (en) begin
            if (up && pos != MAX)
                pos <= pos + 1'b1;
            else if (!up && pos != '0)
                pos <= pos - 1'b1;
        end
    end

    // R4: stops at the top end
    a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == MAX && en && up && !load) |=> (pos == MAX));
    // R4: stops at the bottom end
    a_r4_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0 && en && !up && !load) |=> (pos == '0));
endmodule

// File: rtl/tap_decoder.sv
module tap_decoder #(
    parameter int TAPS = 32,
    parameter int PW   = 5
) (
    input  logic [PW-1:0]   pos,
    output logic [TAPS-1:0] tap
);
    genvar i;
    generate
        for (i = 0; i < TAPS; i++) begin : g_tap
            assign tap[i] = (pos == PW'(i));
        end
    endgenerate
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
    import wiper_pkg::*;
#(
    parameter int TAPS         = 32,
    parameter int STORE_CYCLES = 1000,
    parameter int DEFAULT_POS  = 15
) (
    input  logic            clk,
    input  logic            cold_rst_n,
    input  logic            warm_rst_n,
    input  logic            sel_n,
    input  logic            dir_up,
    input  logic            step_n,
    output logic [TAPS-1:0] tap_sel,
    output logic [4:0]      position,
    output logic            busy,
    output logic            standby
);
    localparam int PW = $clog2(TAPS);
    localparam int CW = $clog2(STORE_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(STORE_CYCLES - 1);

    logic          rst_n;
    logic [2:0]    sync_q;
    logic          sel_lvl, dir_lvl, step_lvl, step_prev, step_fall;
    wstate_e       state_q, state_d;
    logic [CW-1:0] store_cnt;
    logic          cnt_en, cnt_load, nv_we;
    logic [PW-1:0] nv_q, pos_q;

    assign rst_n = cold_rst_n & warm_rst_n;

    sync_bank #(.N(3), .RST_VAL(3'b101)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n, dir_up, step_n}),
        .dout (sync_q)
    );
    assign sel_lvl  = sync_q[2];
    assign dir_lvl  = sync_q[1];
    assign step_lvl = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_prev <= 1'b1;
        else        step_prev <= step_lvl;
    end
    assign step_fall = step_prev & ~step_lvl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RECALL;
            store_cnt <= '0;
        end else begin
            state_q   <= state_d;
            store_cnt <= (state_q == ST_STORE) ? store_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECALL:  state_d = ST_STANDBY;
            ST_STANDBY: if (!sel_lvl) state_d = ST_ACTIVE;
            ST_ACTIVE:  if (sel_lvl)  state_d = step_lvl ? ST_STORE : ST_STANDBY;
            ST_STORE:   if (store_cnt == CNT_LAST) state_d = ST_STANDBY;
            default:    state_d = ST_RECALL;
        endcase
    end

    // outputs
    always_comb begin
        cnt_load = (state_q == ST_RECALL);
        cnt_en   = (state_q == ST_ACTIVE) && !sel_lvl && step_fall;
        nv_we    = (state_q == ST_ACTIVE) && sel_lvl && step_lvl;
        busy     = (state_q == ST_STORE);
        standby  = (state_q == ST_STANDBY);
    end

    // persistent copy: only cold reset clears it
    always_ff @(posedge clk or negedge cold_rst_n) begin
        if (!cold_rst_n)  nv_q <= PW'(DEFAULT_POS);
        else if (nv_we)   nv_q <= pos_q;
    end

    pos_counter #(.PW(PW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(nv_q),
        .en      (cnt_en),
        .up      (dir_lvl),
        .pos     (pos_q)
    );

    tap_decoder #(.TAPS(TAPS), .PW(PW)) u_dec (
        .pos(pos_q),
        .tap(tap_sel)
    );

    assign position = 5'(pos_q);

    // busy run-length tracker for the store window check
    logic [CW-1:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    // R3
    a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tap_sel) == 1) && tap_sel[pos_q]);
    // R5, R8
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY || state_q == ST_STORE) |=> $stable(pos_q));
    // R6
    a_r6_store_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (nv_q == pos_q));
    // R6
    a_r6_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == CW'(STORE_CYCLES)));
    // R7
    a_r7_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && sel_lvl && !step_lvl) |=> ($stable(nv_q) && standby));
endmodule

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int STORE_N    = 30;

    logic        clk = 1'b0;
    logic        cold_rst_n, warm_rst_n, sel_n, dir_up, step_n;
    logic [31:0] tap_sel;
    logic [4:0]  position;
    logic        busy, standby;
    int          n_checks = 0;
    int          n_fail   = 0;
    int          cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_ctrl #(.STORE_CYCLES(STORE_N)) uut (
        .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
        .sel_n(sel_n), .dir_up(dir_up), .step_n(step_n),
        .tap_sel(tap_sel), .position(position), .busy(busy), .standby(standby)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            finish_run();
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_pos(input string req, input int exp);
        check(req, position, exp);
        check({req, " tap"}, (tap_sel == (32'd1 << exp)) ? 1 : 0, 1);
    endtask

    task automatic step(input logic up);
        dir_up = up; wait_clks(1);
        step_n = 1'b0; wait_clks(4);
        step_n = 1'b1; wait_clks(4);
    endtask

    // deselect with step held low: the falling edge itself counts one step
    task automatic deselect_no_store(input logic up);
        dir_up = up; wait_clks(1);
        step_n = 1'b0; wait_clks(4);
        sel_n  = 1'b1; wait_clks(4);
        step_n = 1'b1; wait_clks(2);
    endtask

    task automatic warm_reset();
        warm_rst_n = 1'b0; wait_clks(2);
        warm_rst_n = 1'b1; wait_clks(3);
    endtask

    task automatic t_cold_reset();
        cold_rst_n = 1'b0; wait_clks(3);
        cold_rst_n = 1'b1; wait_clks(3);
        check_pos("R1 cold recall", 15);
        check("R1 busy", busy, 0);
        check("R1 standby", standby, 1);
    endtask

    task automatic t_up_down();
        sel_n = 1'b0; wait_clks(4);
        check("R11 selected standby", standby, 0);
        for (int i = 0; i < 3; i++) step(1'b1);
        check_pos("R2 up", 18);
        for (int i = 0; i < 5; i++) step(1'b0);
        check_pos("R2 down", 13);
        step(1'b1); step(1'b0); step(1'b0); step(1'b1); step(1'b1);
        check_pos("R10 mixed dir", 14);
    endtask

    task automatic t_no_store_and_ignore();
        deselect_no_store(1'b1);
        check("R7 busy", busy, 0);
        check("R11 standby", standby, 1);
        check_pos("R7 pos after deselect", 15);
        for (int i = 0; i < 3; i++) step(1'b0);
        check_pos("R5 unselected steps", 15);
        // move off so the recall value is distinguishable
        sel_n = 1'b0; wait_clks(4);
        step(1'b1); step(1'b1);
        deselect_no_store(1'b1);
        check_pos("R7 pre-warm", 18);
        warm_reset();
        check_pos("R9 warm recall no store", 15);
    endtask

    task automatic t_saturate();
        sel_n = 1'b0; wait_clks(4);
        for (int i = 0; i < 20; i++) step(1'b1);
        check_pos("R4 top", 31);
        for (int i = 0; i < 35; i++) step(1'b0);
        check_pos("R4 bottom", 0);
        for (int i = 0; i < 5; i++) step(1'b1);
        check_pos("R2 up from bottom", 5);
    endtask

    task automatic t_store();
        dir_up = 1'b1;
        sel_n = 1'b1; wait_clks(4);
        check("R6 busy", busy, 1);
        check("R11 standby busy", standby, 0);
        sel_n = 1'b0; wait_clks(1);
        step(1'b1); step(1'b1);
        check("R8 still busy", busy, 1);
        wait_clks(STORE_N + 5);
        check("R6 busy done", busy, 0);
        check_pos("R8 steps ignored", 5);
        step(1'b1);
        check_pos("R2 after store", 6);
        deselect_no_store(1'b1);
        check_pos("R7 pos", 7);
        warm_reset();
        check_pos("R6 R9 stored recall", 5);
        cold_rst_n = 1'b0; wait_clks(2);
        cold_rst_n = 1'b1; wait_clks(3);
        check_pos("R1 cold default", 15);
    endtask

    initial begin
        cold_rst_n = 1'b0; warm_rst_n = 1'b1;
        sel_n = 1'b1; dir_up = 1'b0; step_n = 1'b1;
        wait_clks(2);
        t_cold_reset();
        t_up_down();
        t_no_store_and_ignore();
        t_saturate();
        t_store();
        finish_run();
    end
endmodule